// File: doc/BRIEF.md
# Dual-Copy Bus Driver with Delayed Parity Check

This block sits on a wide data bus and forwards a 12-bit word to two identical output copies. A mode input chooses between a transparent path, where the input word reaches the outputs in the same cycle, and a registered path, where the outputs show the word captured on the last rising clock edge. A hold control freezes the low byte of the capture register while the upper nibble keeps loading. This supports buses whose upper bits change every cycle while the low byte stays fixed.

Parity for a word arrives one clock after the word itself. The block keeps a delayed copy of the captured word so that each parity bit is paired with the word that came before it. It then raises a registered, open-drain style error flag one cycle after the parity bit is sampled. The shared cascade port has two roles. A single unit uses it to choose even or odd checking. In a pair of units, the first unit drives its partial sum on this port and the second unit folds that sum into its own check. One output-enable releases every data copy and the error flag together.

Top module: `dual_bus_parity_drv`

## Requirements
- R1: With `pass_mode` high, both output copies equal `din` in the same cycle, with no clock edge in between.
- R2: With `pass_mode` low, a rising edge with `keep_low` low captures all 12 bits of `din`, and the outputs show that word until the next edge.
- R3: A rising edge with `keep_low` high loads only `din[11:8]` and `par_in`. Bits `[7:0]` of the capture register keep their previous value.
- R4: The parity bit sampled at edge t is checked against the word captured at edge t-1. At edge t+1 the error register takes the XOR of those 12 bits, that parity bit and the polarity term. A value of 1 means a mismatch.
- R5: With `sum_drive_n` high, the polarity term is `cas_in`. A value of 0 checks for even parity and a value of 1 checks for odd parity. When the unit receives a partial sum, that sum is XORed into the check in the same way.
- R6: The error register loads only on an edge where `din[10]` is low. When `din[10]` is high it keeps its value, and `din[10]` still behaves as an ordinary data bit.
- R7: With `sum_drive_n` low, `cas_oe` is 1 and `cas_out` equals the XOR of the delayed word and the stored parity bit. The polarity term is then 0, so `cas_in` has no effect. With `sum_drive_n` high, `cas_oe` and `cas_out` are 0.
- R8: With `oe_n` high, `y_oe` is 0 and `err_pull` is 0. The stored error is kept and reappears on `err_pull` once `oe_n` returns low.
- R9: `err_pull` is 1 only while the error register holds a mismatch and `oe_n` is low. It models the open-drain pull-down of an active-low error line.
- R10: A synchronous active-high `rst` clears the capture register, the delayed copy, the stored parity bit and the error register.
- R11: `y_a` and `y_b` always carry the same word.
- R12: The capture register and the parity check keep clocking while `pass_mode` is high. On a switch back to register mode, the outputs show the word captured at the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 12 | Data word; bit 10 also gates the error register (active low) |
| par_in | input | 1 | Parity bit for the word presented one cycle earlier |
| pass_mode | input | 1 | 1 = transparent path, 0 = registered path |
| keep_low | input | 1 | 1 = hold bits [7:0] of the capture register |
| oe_n | input | 1 | Active-low enable for all output copies and the error line |
| sum_drive_n | input | 1 | 0 = drive the partial sum on the cascade port |
| cas_in | input | 1 | Cascade port input: polarity select or incoming partial sum |
| y_a | output | 12 | First output copy |
| y_b | output | 12 | Second output copy |
| y_oe | output | 1 | Drive enable of both output copies |
| cas_out | output | 1 | Partial parity sum driven on the cascade port |
| cas_oe | output | 1 | Drive enable of the cascade port |
| err_pull | output | 1 | 1 = pull the open-drain error line low |

## Verification
The bench compares against a cycle model written from the requirements and runs stimulus across the one-cycle parity lag. If the design paired the parity bit with the current word instead of the delayed one, the flag would rise or fall one cycle early. If the error register were not gated by bit 10, a mismatch would be overwritten during a hold window. The bench applies words where only the low byte differs, both with the hold active and with it inactive. A design that held the wrong group would then show changed low bits or a frozen upper nibble. Further checks toggle the output enable while an error is stored, return from transparent mode after several edges, and drive a conflicting `cas_in` while the unit is driving its partial sum. These show whether the stored state survives and whether the port input is ignored.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
   parameter int unsigned PBD_WIDTH_DEF  = 12;
   parameter int unsigned PBD_HOLD_DEF   = 8;
   parameter int unsigned PBD_GATE_DEF   = 10;
   parameter int unsigned PBD_COPIES_DEF = 2;

   typedef enum logic {
      POL_EVEN = 1'b0,
      POL_ODD  = 1'b1
   } par_pol_e;
endpackage

// File: rtl/pbd_capture.sv
module pbd_capture #(
   parameter int unsigned WIDTH     = 12,
   parameter int unsigned HOLD_BITS = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pass_mode,
   input  logic             keep_low,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] word_q,
   output logic [WIDTH-1:0] dly_q,
   output logic [WIDTH-1:0] y_word
);
   localparam int unsigned UPPER_LO = HOLD_BITS;

   generate
      if (HOLD_BITS == 0) begin : g_flat
         logic unused_keep;
         assign unused_keep = keep_low;
         always_ff @(posedge clk) begin
            if (rst) word_q <= '0;
            else     word_q <= din;
         end
      end else begin : g_split
         always_ff @(posedge clk) begin
            if (rst) begin
               word_q <= '0;
            end else begin
               word_q[WIDTH-1:UPPER_LO] <= din[WIDTH-1:UPPER_LO];
               if (!keep_low) word_q[UPPER_LO-1:0] <= din[UPPER_LO-1:0];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) dly_q <= '0;
      else     dly_q <= word_q;
   end

   assign y_word = pass_mode ? din : word_q;
endmodule

// File: rtl/pbd_check_core.sv
module pbd_check_core
   import pbd_pkg::*;
#(
   parameter int unsigned WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] dly_q,
   input  logic             par_in,
   input  logic             gate_n,
   input  logic             sum_drive_n,
   input  logic             cas_in,
   output logic             psum,
   output logic             err_q
);
   logic     par_q;
   par_pol_e pol;
   logic     mismatch;

   always_ff @(posedge clk) begin
      if (rst) par_q <= 1'b0;
      else     par_q <= par_in;
   end

   assign psum     = (^dly_q) ^ par_q;
   assign pol      = sum_drive_n ? par_pol_e'(cas_in) : POL_EVEN;
   assign mismatch = psum ^ logic'(pol);

   always_ff @(posedge clk) begin
      if (rst)          err_q <= 1'b0;
      else if (!gate_n) err_q <= mismatch;
   end
endmodule

// File: rtl/pbd_out_stage.sv
module pbd_out_stage #(
   parameter int unsigned WIDTH  = 12,
   parameter int unsigned COPIES = 2
) (
   input  logic                         oe_n,
   input  logic                         sum_drive_n,
   input  logic [WIDTH-1:0]             y_word,
   input  logic                         err_q,
   input  logic                         psum,
   output logic [COPIES-1:0][WIDTH-1:0] y_rep,
   output logic                         y_oe,
   output logic                         err_pull,
   output logic                         cas_out,
   output logic                         cas_oe
);
   generate
      for (genvar c = 0; c < COPIES; c++) begin : g_copy
         assign y_rep[c] = y_word;
      end
   endgenerate

   assign y_oe     = ~oe_n;
   assign err_pull = err_q & ~oe_n;
   assign cas_oe   = ~sum_drive_n;
   assign cas_out  = psum & ~sum_drive_n;
endmodule

// File: rtl/dual_bus_parity_drv.sv
module dual_bus_parity_drv
   import pbd_pkg::*;
#(
   parameter int unsigned WIDTH     = PBD_WIDTH_DEF,
   parameter int unsigned HOLD_BITS = PBD_HOLD_DEF,
   parameter int unsigned GATE_BIT  = PBD_GATE_DEF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   input  logic             par_in,
   input  logic             pass_mode,
   input  logic             keep_low,
   input  logic             oe_n,
   input  logic             sum_drive_n,
   input  logic             cas_in,
   output logic [WIDTH-1:0] y_a,
   output logic [WIDTH-1:0] y_b,
   output logic             y_oe,
   output logic             cas_out,
   output logic             cas_oe,
   output logic             err_pull
);
   localparam int unsigned COPIES = PBD_COPIES_DEF;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dual_bus_parity_drv: WIDTH must be at least 2");
      end
      if (HOLD_BITS >= WIDTH) begin : g_bad_hold
         $error("dual_bus_parity_drv: HOLD_BITS must be below WIDTH");
      end
      if (GATE_BIT >= WIDTH) begin : g_bad_gate
         $error("dual_bus_parity_drv: GATE_BIT must index a data bit");
      end
   endgenerate

   logic [WIDTH-1:0]             word_q;
   logic [WIDTH-1:0]             dly_q;
   logic [WIDTH-1:0]             y_word;
   logic                         psum;
   logic                         err_q;
   logic [COPIES-1:0][WIDTH-1:0] y_rep;

   pbd_capture #(.WIDTH(WIDTH), .HOLD_BITS(HOLD_BITS)) u_capture (
      .clk       (clk),
      .rst       (rst),
      .pass_mode (pass_mode),
      .keep_low  (keep_low),
      .din       (din),
      .word_q    (word_q),
      .dly_q     (dly_q),
      .y_word    (y_word)
   );

   pbd_check_core #(.WIDTH(WIDTH)) u_check (
      .clk         (clk),
      .rst         (rst),
      .dly_q       (dly_q),
      .par_in      (par_in),
      .gate_n      (din[GATE_BIT]),
      .sum_drive_n (sum_drive_n),
      .cas_in      (cas_in),
      .psum        (psum),
      .err_q       (err_q)
   );

   pbd_out_stage #(.WIDTH(WIDTH), .COPIES(COPIES)) u_out (
      .oe_n        (oe_n),
      .sum_drive_n (sum_drive_n),
      .y_word      (y_word),
      .err_q       (err_q),
      .psum        (psum),
      .y_rep       (y_rep),
      .y_oe        (y_oe),
      .err_pull    (err_pull),
      .cas_out     (cas_out),
      .cas_oe      (cas_oe)
   );

   assign y_a = y_rep[0];
   assign y_b = y_rep[1];
endmodule

// File: rtl/pbd_props.sv
module pbd_props #(
   parameter int unsigned WIDTH    = 12,
   parameter int unsigned GATE_BIT = 10
) (
   input logic             clk,
   input logic             rst,
   input logic             pass_mode,
   input logic             keep_low,
   input logic             oe_n,
   input logic             sum_drive_n,
   input logic [WIDTH-1:0] din,
   input logic [WIDTH-1:0] y_a,
   input logic [WIDTH-1:0] y_b,
   input logic             y_oe,
   input logic             err_pull,
   input logic             cas_oe,
   input logic [WIDTH-1:0] word_q,
   input logic             err_q
);
   // R1
   pass_through_chk: assert property (@(posedge clk) disable iff (rst)
      pass_mode |-> (y_a == din));

   // R2
   full_load_chk: assert property (@(posedge clk) disable iff (rst)
      !keep_low |=> (word_q == $past(din)));

   // R6
   err_hold_chk: assert property (@(posedge clk) disable iff (rst)
      din[GATE_BIT] |=> $stable(err_q));

   // R7
   cas_dir_chk: assert property (@(posedge clk) disable iff (rst)
      cas_oe == !sum_drive_n);

   // R8
   release_chk: assert property (@(posedge clk) disable iff (rst)
      oe_n |-> (!y_oe && !err_pull));

   // R10
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (word_q == '0 && !err_q));

   // R11
   copy_match_chk: assert property (@(posedge clk) disable iff (rst)
      y_a == y_b);
endmodule

bind dual_bus_parity_drv pbd_props #(.WIDTH(WIDTH), .GATE_BIT(GATE_BIT)) u_props (
   .clk         (clk),
   .rst         (rst),
   .pass_mode   (pass_mode),
   .keep_low    (keep_low),
   .oe_n        (oe_n),
   .sum_drive_n (sum_drive_n),
   .din         (din),
   .y_a         (y_a),
   .y_b         (y_b),
   .y_oe        (y_oe),
   .err_pull    (err_pull),
   .cas_oe      (cas_oe),
   .word_q      (word_q),
   .err_q       (err_q)
);

// File: tb/dual_bus_parity_drv_test.sv
`timescale 1ns/1ps
module dual_bus_parity_drv_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] din = '0;
   logic        par_in = 1'b0;
   logic        pass_mode = 1'b0;
   logic        keep_low = 1'b0;
   logic        oe_n = 1'b0;
   logic        sum_drive_n = 1'b1;
   logic        cas_in = 1'b0;
   logic [11:0] y_a, y_b;
   logic        y_oe, cas_out, cas_oe, err_pull;

   always #2 clk = ~clk;

   dual_bus_parity_drv uut (
      .clk(clk), .rst(rst), .din(din), .par_in(par_in), .pass_mode(pass_mode),
      .keep_low(keep_low), .oe_n(oe_n), .sum_drive_n(sum_drive_n), .cas_in(cas_in),
      .y_a(y_a), .y_b(y_b), .y_oe(y_oe), .cas_out(cas_out), .cas_oe(cas_oe),
      .err_pull(err_pull)
   );

   typedef struct {
      logic [11:0] y;
      logic        oe;
      logic        co;
      logic        coe;
      logic        ep;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   vectors = 0;
   int   misses  = 0;
   bit   done    = 1'b0;

   // reference model state
   logic [11:0] m_w = '0, m_d = '0;
   logic        m_p = 1'b0, m_e = 1'b0;

   task automatic step(input logic r, input logic [11:0] d, input logic p,
                       input logic pm, input logic kl, input logic oen,
                       input logic sdn, input logic ci, input string tag);
      exp_t e;
      logic ne;
      @(posedge clk);
      if (rst) begin
         m_w = '0; m_d = '0; m_p = 1'b0; m_e = 1'b0;
      end else begin
         ne = m_e;
         if (!din[10]) ne = (^m_d) ^ m_p ^ (sum_drive_n ? cas_in : 1'b0);
         m_d = m_w;
         m_w[11:8] = din[11:8];
         if (!keep_low) m_w[7:0] = din[7:0];
         m_p = par_in;
         m_e = ne;
      end
      #1;
      rst = r; din = d; par_in = p; pass_mode = pm; keep_low = kl;
      oe_n = oen; sum_drive_n = sdn; cas_in = ci;
      e.y   = pm ? d : m_w;
      e.oe  = !oen;
      e.coe = !sdn;
      e.co  = !sdn ? ((^m_d) ^ m_p) : 1'b0;
      e.ep  = m_e & !oen;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            vectors++;
            if (y_a !== e.y || y_b !== e.y || y_oe !== e.oe || cas_out !== e.co ||
                cas_oe !== e.coe || err_pull !== e.ep) begin
               misses++;
               $display("FAIL %s: y_a=%h y_b=%h y_oe=%b cas_out=%b cas_oe=%b err_pull=%b | expected y=%h y_oe=%b cas_out=%b cas_oe=%b err_pull=%b",
                        e.tag, y_a, y_b, y_oe, cas_out, cas_oe, err_pull,
                        e.y, e.oe, e.co, e.coe, e.ep);
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         misses++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      // R10 reset state
      step(1, 12'h000, 0, 0, 0, 0, 1, 0, "R10");
      step(1, 12'h000, 0, 0, 0, 0, 1, 0, "R10");
      step(0, 12'hA35, 0, 0, 0, 0, 1, 0, "R10");
      // R2 full capture, R11 copies
      step(0, 12'h9CA, 0, 0, 0, 0, 1, 0, "R2");
      step(0, 12'h2F1, 1, 0, 0, 0, 1, 0, "R2");
      step(0, 12'h0B4, 0, 0, 0, 0, 1, 0, "R11");
      // R1 transparent, R12 registers keep clocking
      step(0, 12'h3C3, 0, 1, 0, 0, 1, 0, "R1");
      step(0, 12'hFFF, 0, 1, 0, 0, 1, 0, "R1");
      step(0, 12'h5A5, 1, 1, 0, 0, 1, 0, "R12");
      step(0, 12'h000, 0, 0, 0, 0, 1, 0, "R12");
      // R3 low-byte hold
      step(0, 12'h123, 0, 0, 1, 0, 1, 0, "R3");
      step(0, 12'h8EE, 0, 0, 1, 0, 1, 0, "R3");
      step(0, 12'h377, 1, 0, 1, 0, 1, 0, "R3");
      step(0, 12'h0CC, 0, 0, 0, 0, 1, 0, "R3");
      // R4 good then bad even parity, gate low
      step(0, 12'h00F, 0, 0, 0, 0, 1, 0, "R4");
      step(0, 12'h007, 0, 0, 0, 0, 1, 0, "R4");
      step(0, 12'h003, 0, 0, 0, 0, 1, 0, "R4");
      step(0, 12'h001, 0, 0, 0, 0, 1, 0, "R4");
      step(0, 12'h000, 1, 0, 0, 0, 1, 0, "R4");
      step(0, 12'h000, 0, 0, 0, 0, 1, 0, "R9");
      step(0, 12'h000, 0, 0, 0, 0, 1, 0, "R9");
      // R5 odd polarity
      step(0, 12'h007, 0, 0, 0, 0, 1, 1, "R5");
      step(0, 12'h00F, 1, 0, 0, 0, 1, 1, "R5");
      step(0, 12'h000, 0, 0, 0, 0, 1, 1, "R5");
      step(0, 12'h000, 1, 0, 0, 0, 1, 1, "R5");
      step(0, 12'h000, 0, 0, 0, 0, 1, 0, "R5");
      // R6 gate bit high holds error
      step(0, 12'h003, 0, 0, 0, 0, 1, 0, "R6");
      step(0, 12'h400, 1, 0, 0, 0, 1, 0, "R6");
      step(0, 12'h401, 0, 0, 0, 0, 1, 0, "R6");
      step(0, 12'h400, 0, 0, 0, 0, 1, 0, "R6");
      step(0, 12'h000, 1, 0, 0, 0, 1, 0, "R6");
      step(0, 12'h000, 0, 0, 0, 0, 1, 0, "R6");
      // R7 driving partial sum, cas_in ignored
      step(0, 12'h00B, 1, 0, 0, 0, 0, 1, "R7");
      step(0, 12'h001, 0, 0, 0, 0, 0, 1, "R7");
      step(0, 12'h000, 1, 0, 0, 0, 0, 1, "R7");
      step(0, 12'h000, 0, 0, 0, 0, 0, 1, "R7");
      step(0, 12'h000, 0, 0, 0, 0, 1, 0, "R7");
      // R8 release keeps stored error
      step(0, 12'h007, 0, 0, 0, 0, 1, 0, "R8");
      step(0, 12'h000, 0, 0, 0, 1, 1, 0, "R8");
      step(0, 12'h400, 0, 0, 0, 1, 1, 0, "R8");
      step(0, 12'h400, 0, 0, 0, 1, 1, 0, "R8");
      step(0, 12'h400, 0, 0, 0, 0, 1, 0, "R8");
      // R10 reset while error stored
      step(1, 12'h000, 0, 0, 0, 0, 1, 0, "R10");
      step(0, 12'h000, 0, 0, 0, 0, 1, 0, "R10");
      // mixed traffic, R4
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a;
         a = $urandom;
         step((a[31:26] == 6'd0), a[11:0], a[12], a[13] & a[14], a[15],
              (a[18:16] == 3'd0), a[19] | a[20], a[21], "R4");
      end
      step(0, 12'h000, 0, 0, 0, 0, 1, 0, "R4");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule